// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a register of configurable width (eight stages by default) that can keep its value, move its contents one stage in either direction, or capture a full parallel word in one clock. A two-bit select chooses the operation on every rising clock edge. An active-low clear, sampled on the clock, zeroes every stage and overrides whatever the select asks for.

The parallel data shares one set of pads, which is modelled here as a split pad interface: a sampled input vector, a driven output vector and a per-pad drive enable. The pads are driven with the stored word only while both active-low output enables are low and the block is not loading. Selecting parallel load turns the pad drivers off so that an external source can place a word on the pads to be captured. The two end stages are also brought out on two serial outputs that are always driven. This lets several instances be chained into a longer register, with each neighbour's serial output feeding the next serial input.

Top module: `ushift_reg`

## Requirements
- R1: With select = 2'b00 at a rising edge and clear high, every stage keeps its value.
- R2: With select = 2'b01 (right), stage i takes the old stage i-1 and stage 0 takes `ser_right_in`.
- R3: With select = 2'b10 (left), stage i takes the old stage i+1 and the top stage (index WIDTH-1) takes `ser_left_in`.
- R4: With select = 2'b11 (load), every stage i takes `pad_in[i]` at the rising edge.
- R5: When `clr_n` is low at a rising edge, every stage becomes 0, whatever the select value, load included.
- R6: While select = 2'b11, `pad_oe` is all zeros, with no clock delay.
- R7: While `oe1_n` or `oe2_n` is high, `pad_oe` is all zeros, and hold, shift, load and clear proceed exactly as with the pads enabled.
- R8: While both enables are low and select is not 2'b11, `pad_oe` is all ones and `pad_out` equals the stored word.
- R9: `ser_first_out` always equals stage 0 and `ser_last_out` always equals stage WIDTH-1, independent of enables and select.
- R10: Two instances chained (first `ser_last_out` to second `ser_right_in`, second `ser_first_out` to first `ser_left_in`) act as one register of twice the width, with the first instance's stage 0 as the overall stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| sel | input | 2 | Operation select: 00 hold, 01 right, 10 left, 11 load |
| ser_right_in | input | 1 | Serial data entering stage 0 on a right shift |
| ser_left_in | input | 1 | Serial data entering the top stage on a left shift |
| oe1_n | input | 1 | Pad output enable, active low |
| oe2_n | input | 1 | Pad output enable, active low |
| pad_in | input | WIDTH | Value present on the shared pads |
| pad_out | output | WIDTH | Value driven onto the pads (zero while not driving) |
| pad_oe | output | WIDTH | Per-pad drive enable |
| ser_first_out | output | 1 | Stage 0, always driven |
| ser_last_out | output | 1 | Stage WIDTH-1, always driven |

## Verification
A corrupted stage appears on the serial end outputs at once if it sits at an end, and otherwise on `pad_out` in the next cycle in which the pads are enabled; a right or left shift moves an inner fault to an end output within WIDTH-1 edges. Because disabled pads hide the word, the bench follows every hidden stretch with enabled cycles so that a wrong capture during load or during disabled operation is exposed one edge later. A wrong drive-enable decode is visible immediately, since `pad_oe` depends only on the current inputs.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_RIGHT = 2'b01,
        OP_LEFT  = 2'b10,
        OP_LOAD  = 2'b11
    } op_e;

    typedef struct packed {
        logic clear;
        op_e  op;
        logic ser_r;
        logic ser_l;
    } ctrl_t;

    function automatic ctrl_t make_ctrl(input logic clr_n, input logic [1:0] sel,
                                        input logic sr, input logic sl);
        ctrl_t c;
        c.clear = ~clr_n;
        c.op    = op_e'(sel);
        c.ser_r = sr;
        c.ser_l = sl;
        return c;
    endfunction

    function automatic logic pads_driven(input op_e op, input logic oe1_n, input logic oe2_n);
        return (~oe1_n) & (~oe2_n) & (op != OP_LOAD);
    endfunction

endpackage

// File: rtl/ushift_core.sv
module ushift_core
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  ctrl_t            ctrl,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_lower;
        logic from_upper;
        if (i == 0) begin : g_low_end
            assign from_lower = ctrl.ser_r;
        end else begin : g_low_mid
            assign from_lower = stage[i-1];
        end
        if (i == TOP) begin : g_high_end
            assign from_upper = ctrl.ser_l;
        end else begin : g_high_mid
            assign from_upper = stage[i+1];
        end

        always_comb begin
            unique case (ctrl.op)
                OP_HOLD:  nxt[i] = stage[i];
                OP_RIGHT: nxt[i] = from_lower;
                OP_LEFT:  nxt[i] = from_upper;
                default:  nxt[i] = par_in[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (ctrl.clear) stage <= '0;
        else            stage <= nxt;
    end

    // R5: clear wins over every operation
    a_r5_clear_zero: assert property (@(posedge clk)
        ctrl.clear |=> (stage == '0));

    // R1
    a_r1_hold_stable: assert property (@(posedge clk) disable iff (ctrl.clear)
        (ctrl.op == OP_HOLD) |=> $stable(stage));

    // R2
    a_r2_shift_right: assert property (@(posedge clk) disable iff (ctrl.clear)
        (ctrl.op == OP_RIGHT) |=> (stage == {$past(stage[TOP-1:0]), $past(ctrl.ser_r)}));

    // R3
    a_r3_shift_left: assert property (@(posedge clk) disable iff (ctrl.clear)
        (ctrl.op == OP_LEFT) |=> (stage == {$past(ctrl.ser_l), $past(stage[TOP:1])}));

    // R4
    a_r4_load_capture: assert property (@(posedge clk) disable iff (ctrl.clear)
        (ctrl.op == OP_LOAD) |=> (stage == $past(par_in)));

endmodule

// File: rtl/ushift_pad_drv.sv
module ushift_pad_drv
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic [WIDTH-1:0] stage,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    logic drive;

    assign drive = pads_driven(op, oe1_n, oe2_n);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pad
        assign pad_oe[i]  = drive;
        assign pad_out[i] = drive & stage[i];
    end

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       sel,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic             ser_first_out,
    output logic             ser_last_out
);
    localparam int TOP = WIDTH - 1;

    ctrl_t            ctrl;
    logic [WIDTH-1:0] stage;

    assign ctrl = make_ctrl(clr_n, sel, ser_right_in, ser_left_in);

    ushift_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .ctrl   (ctrl),
        .par_in (pad_in),
        .stage  (stage)
    );

    ushift_pad_drv #(.WIDTH(WIDTH)) u_pads (
        .op      (ctrl.op),
        .oe1_n   (oe1_n),
        .oe2_n   (oe2_n),
        .stage   (stage),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign ser_first_out = stage[0];
    assign ser_last_out  = stage[TOP];

    // R6: load releases the pads
    a_r6_load_releases: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b11) |-> (pad_oe == '0));

    // R7: a high enable releases the pads
    a_r7_enable_gates: assert property (@(posedge clk) disable iff (!clr_n)
        (oe1_n || oe2_n) |-> (pad_oe == '0));

    // R8: enabled pads show the word on every pad
    a_r8_enabled_shows: assert property (@(posedge clk) disable iff (!clr_n)
        (!oe1_n && !oe2_n && sel != 2'b11) |-> ((pad_oe == '1) && (pad_out == stage)));

endmodule

// File: tb/ushift_reg_tb_top.sv
module ushift_reg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // single instance
    logic         clr_n, sr, sl, oe1_n, oe2_n;
    logic [1:0]   sel;
    logic [W-1:0] pin, pout, poe;
    logic         qf, ql;

    ushift_reg #(.WIDTH(W)) dut_i (
        .clk(clk), .clr_n(clr_n), .sel(sel), .ser_right_in(sr), .ser_left_in(sl),
        .oe1_n(oe1_n), .oe2_n(oe2_n), .pad_in(pin), .pad_out(pout), .pad_oe(poe),
        .ser_first_out(qf), .ser_last_out(ql)
    );

    // chained pair (R10)
    logic         c_clr_n, c_sr, c_sl;
    logic [1:0]   c_sel;
    logic [W-1:0] c_in0, c_in1, c_out0, c_out1, c_oe0, c_oe1;
    logic         c0_first, c0_last, c1_first, c1_last;

    ushift_reg #(.WIDTH(W)) chain0 (
        .clk(clk), .clr_n(c_clr_n), .sel(c_sel), .ser_right_in(c_sr), .ser_left_in(c1_first),
        .oe1_n(1'b0), .oe2_n(1'b0), .pad_in(c_in0), .pad_out(c_out0), .pad_oe(c_oe0),
        .ser_first_out(c0_first), .ser_last_out(c0_last)
    );
    ushift_reg #(.WIDTH(W)) chain1 (
        .clk(clk), .clr_n(c_clr_n), .sel(c_sel), .ser_right_in(c0_last), .ser_left_in(c_sl),
        .oe1_n(1'b0), .oe2_n(1'b0), .pad_in(c_in1), .pad_out(c_out1), .pad_oe(c_oe1),
        .ser_first_out(c1_first), .ser_last_out(c1_last)
    );

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur, input logic cn,
            input logic [1:0] s, input logic r, input logic l, input logic [W-1:0] p);
        if (!cn) return '0;
        case (s)
            2'b00:   return cur;
            2'b01:   return {cur[W-2:0], r};
            2'b10:   return {l, cur[W-1:1]};
            default: return p;
        endcase
    endfunction

    function automatic logic [2*W-1:0] ref_next2(input logic [2*W-1:0] cur, input logic cn,
            input logic [1:0] s, input logic r, input logic l, input logic [2*W-1:0] p);
        if (!cn) return '0;
        case (s)
            2'b00:   return cur;
            2'b01:   return {cur[2*W-2:0], r};
            2'b10:   return {l, cur[2*W-1:1]};
            default: return p;
        endcase
    endfunction

    function automatic string op_tag(input logic cn, input logic [1:0] s);
        if (!cn) return "R5";
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    logic [W-1:0] model;
    string last_tag = "R5";
    bit hidden = 1'b0;

    // drive at negedge, clock, then compare away from the edge
    task automatic step(input logic cn, input logic [1:0] s, input logic r, input logic l,
                        input logic o1, input logic o2, input logic [W-1:0] p);
        logic drive;
        @(negedge clk);
        clr_n = cn; sel = s; sr = r; sl = l; oe1_n = o1; oe2_n = o2; pin = p;
        @(posedge clk);
        model = ref_next(model, cn, s, r, l, p);
        #1;
        drive = !o1 && !o2 && (s != 2'b11);
        check(poe == (drive ? {W{1'b1}} : {W{1'b0}}),
              (s == 2'b11) ? "R6" : ((o1 || o2) ? "R7" : "R8"), 32'(poe), drive ? 32'hFF : 32'h0);
        if (drive) begin
            // a word captured while hidden is first seen here
            check(pout == model, hidden ? "R7" : (last_tag == "R5" ? "R5" : op_tag(cn, s)),
                  32'(pout), 32'(model));
            hidden = 1'b0;
        end else if (o1 || o2) begin
            hidden = 1'b1;
        end
        last_tag = op_tag(cn, s);
        check({ql, qf} == {model[W-1], model[0]}, "R9", 32'({ql, qf}), 32'({model[W-1], model[0]}));
    endtask

    logic [2*W-1:0] cmodel;

    task automatic cstep(input logic cn, input logic [1:0] s, input logic r, input logic l,
                         input logic [2*W-1:0] p);
        @(negedge clk);
        c_clr_n = cn; c_sel = s; c_sr = r; c_sl = l; c_in0 = p[W-1:0]; c_in1 = p[2*W-1:W];
        @(posedge clk);
        cmodel = ref_next2(cmodel, cn, s, r, l, p);
        #1;
        check({c1_last, c0_first} == {cmodel[2*W-1], cmodel[0]}, "R10",
              32'({c1_last, c0_first}), 32'({cmodel[2*W-1], cmodel[0]}));
        if (s != 2'b11)
            check({c_out1, c_out0} == cmodel, "R10", 32'({c_out1, c_out0}), 32'(cmodel));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        clr_n = 1'b0; sel = 2'b00; sr = 1'b0; sl = 1'b0; oe1_n = 1'b0; oe2_n = 1'b0; pin = '0;
        c_clr_n = 1'b0; c_sel = 2'b00; c_sr = 1'b0; c_sl = 1'b0; c_in0 = '0; c_in1 = '0;
        model = '0; cmodel = '0;

        // reset state (R5)
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        // R4 load, then R1 hold
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        // R2 right, R3 left with distinct serial values
        step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        // R5 clear beats load
        step(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        // R7 ops under disabled pads, then revealed
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C);
        step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        // R7 clear while disabled
        step(1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

        // random mix
        for (int k = 0; k < 600; k++) begin
            logic cn;
            cn = ($urandom % 16) != 0;
            step(cn, 2'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, ($urandom % 4) == 0, W'($urandom));
        end

        // chained pair: clear, load, walk both ways (R10)
        cstep(1'b0, 2'b00, 1'b0, 1'b0, 16'h0000);
        cstep(1'b1, 2'b11, 1'b0, 1'b0, 16'h8001);
        for (int k = 0; k < 9; k++) cstep(1'b1, 2'b01, 1'b0, 1'b0, 16'h0000);
        for (int k = 0; k < 9; k++) cstep(1'b1, 2'b10, 1'b1, 1'b1, 16'h0000);
        for (int k = 0; k < 300; k++) begin
            cstep(($urandom % 20) != 0, 2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule